// File: doc/BRIEF.md
# RTC Alarm Match and Interrupt Unit

This block sits beside a real-time clock's counter chain. It holds six alarm registers, one for each of the time fields: seconds, minutes, hours, date, month and weekday. It also holds a control register. The time chain presents the freshly advanced BCD time on `time_i`, together with a one-cycle `tick_i` strobe. On that strobe the block compares the enabled alarm fields against the time. When every enabled field is equal, it sets an alarm flag and, if interrupts are enabled, pulls the active-low interrupt line.

There are two signalling modes. In latched mode the interrupt is held until the host clears the flag. In pulsed mode each match produces a low pulse of fixed width, and the flag is set again on every hit without the host having to service it. A typical pulsed setup enables only the seconds field at 30, which gives one pulse per minute.

Top module: `rtc_alarm_irq`

## Requirements
- R1: Writes with `wr_en_i` high store `wr_data_i` at `wr_addr_i`. Addresses 0 to 5 are the alarm fields, in the order seconds, minutes, hours, date, month, weekday. Each field holds its enable in bit 7 and its BCD value in bits 6..0. Address 6 is control. A write to address 7 changes nothing. After reset all registers are zero, `alm_o` is 0 and `irq_no` is 1.
- R2: A match is evaluated only in a cycle with `tick_i` high, against the `time_i` of that cycle. `alm_o` rises on the following clock edge.
- R3: Only fields whose enable bit is 1 take part in the comparison. Time fields whose alarm enable is 0 have no effect on the outcome.
- R4: With all six enable bits at 0, no tick ever produces a match.
- R5: Control bit 7 enables alarm matching; with it at 0 no match occurs. Control bit 6 enables the interrupt; with it at 0 `irq_no` stays high while `alm_o` still sets.
- R6: In latched mode (control bit 5 = 0), `irq_no` is low exactly while `alm_o` is 1 and control bit 6 is 1. A further match while the flag is set gives no new edge.
- R7: A `clr_alm_i` strobe clears `alm_o` on the next edge. A match in the same cycle takes priority and keeps the flag set.
- R8: In pulsed mode (control bit 5 = 1), each match sets `alm_o` and drives `irq_no` low for exactly `PULSE_W` cycles, starting the cycle after the tick. A match during a pulse restarts it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe: time has just advanced |
| time_i | input | 42 | Current BCD time, field k at bits [7k+6:7k] (sec, min, hour, date, month, weekday) |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 8 | Register write data |
| clr_alm_i | input | 1 | Alarm flag clear strobe |
| alm_o | output | 1 | Alarm status flag |
| irq_no | output | 1 | Active-low interrupt |

## Verification
Register writes take effect at the edge that samples them. A tick's match sets `alm_o` and drives `irq_no` at the next edge, and a clear acts at the next edge. A pulse is low for `PULSE_W` consecutive cycles after the tick edge. The bench changes inputs on falling edges and updates a reference model at the rising edge that the design samples. It compares both outputs at the following falling edge, so every result is checked in the first cycle it is due and in every cycle after. The pulsed-mode scenario also counts falling edges of `irq_no` over two simulated minutes.

// File: rtl/rtc_alarm_pkg.sv
package rtc_alarm_pkg;
  localparam int NUM_FIELDS  = 6;
  localparam int FIELD_W     = 7;
  localparam int ADDR_W      = 3;
  localparam int CTRL_ADDR   = 6;
  localparam int CTRL_ALM_EN = 7;
  localparam int CTRL_INT_EN = 6;
  localparam int CTRL_PULSED = 5;

  typedef struct packed {
    logic alm_en;
    logic int_en;
    logic pulsed;
  } ctrl_t;
endpackage

// File: rtl/rtc_alarm_regs.sv
module rtc_alarm_regs
  import rtc_alarm_pkg::*;
#(
  parameter int NF = NUM_FIELDS,
  parameter int FW = FIELD_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [NF-1:0]     en_o,
  output logic [NF*FW-1:0]  val_o,
  output ctrl_t             ctrl_o
);
  for (genvar k = 0; k < NF; k++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_o[k]          <= 1'b0;
        val_o[k*FW +: FW] <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(k)) begin
        en_o[k]          <= wr_data_i[7];
        val_o[k*FW +: FW] <= wr_data_i[FW-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o <= '0;
    end else if (wr_en_i && wr_addr_i == ADDR_W'(CTRL_ADDR)) begin
      ctrl_o.alm_en <= wr_data_i[CTRL_ALM_EN];
      ctrl_o.int_en <= wr_data_i[CTRL_INT_EN];
      ctrl_o.pulsed <= wr_data_i[CTRL_PULSED];
    end
  end
endmodule

// File: rtl/rtc_alarm_match.sv
module rtc_alarm_match #(
  parameter int NF = 6,
  parameter int FW = 7
) (
  input  logic             tick_i,
  input  logic             alm_en_i,
  input  logic [NF-1:0]    en_i,
  input  logic [NF*FW-1:0] val_i,
  input  logic [NF*FW-1:0] time_i,
  output logic             hit_o
);
  logic [NF-1:0] fld_ok;

  for (genvar k = 0; k < NF; k++) begin : g_cmp
    assign fld_ok[k] = !en_i[k] || (val_i[k*FW +: FW] == time_i[k*FW +: FW]);
  end

  // at least one field must be armed
  assign hit_o = tick_i && alm_en_i && (|en_i) && (&fld_ok);
endmodule

// File: rtl/rtc_irq_gen.sv
module rtc_irq_gen #(
  parameter int PULSE_W = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic hit_i,
  input  logic clr_i,
  input  logic int_en_i,
  input  logic pulsed_i,
  output logic alm_o,
  output logic irq_no
);
  localparam int CW = $clog2(PULSE_W + 1);

  logic [CW-1:0] cnt_q;
  logic          alm_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      if (hit_i)      alm_q <= 1'b1;
      else if (clr_i) alm_q <= 1'b0;
      if (hit_i && pulsed_i) cnt_q <= CW'(PULSE_W);
      else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end
  end

  assign alm_o  = alm_q;
  assign irq_no = !(int_en_i && (pulsed_i ? (cnt_q != '0) : alm_q));
endmodule

// File: rtl/rtc_alarm_irq.sv
module rtc_alarm_irq
  import rtc_alarm_pkg::*;
#(
  parameter int PULSE_W = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          tick_i,
  input  logic [NUM_FIELDS*FIELD_W-1:0] time_i,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [7:0]                    wr_data_i,
  input  logic                          clr_alm_i,
  output logic                          alm_o,
  output logic                          irq_no
);
  logic [NUM_FIELDS-1:0]         fld_en;
  logic [NUM_FIELDS*FIELD_W-1:0] fld_val;
  ctrl_t                         ctrl_q;
  logic                          hit;

  rtc_alarm_regs #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .en_o(fld_en), .val_o(fld_val), .ctrl_o(ctrl_q)
  );

  rtc_alarm_match #(.NF(NUM_FIELDS), .FW(FIELD_W)) u_match (
    .tick_i, .alm_en_i(ctrl_q.alm_en), .en_i(fld_en),
    .val_i(fld_val), .time_i, .hit_o(hit)
  );

  rtc_irq_gen #(.PULSE_W(PULSE_W)) u_irq (
    .clk_i, .rst_ni, .hit_i(hit), .clr_i(clr_alm_i),
    .int_en_i(ctrl_q.int_en), .pulsed_i(ctrl_q.pulsed),
    .alm_o, .irq_no
  );
endmodule

// File: rtl/rtc_alarm_irq_chk.sv
module rtc_alarm_irq_chk #(
  parameter int PULSE_W = 4,
  parameter int NF      = 6
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tick_i,
  input logic          clr_alm_i,
  input logic          alm_o,
  input logic          irq_no,
  input logic          hit_i,
  input logic [NF-1:0] en_i,
  input logic          alm_en_i,
  input logic          int_en_i,
  input logic          pulsed_i
);
  logic [15:0] low_run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                             low_run <= '0;
    else if (hit_i)                          low_run <= '0;
    else if (!irq_no && pulsed_i && int_en_i) low_run <= low_run + 1'b1;
    else                                     low_run <= '0;
  end

  a_r2_rise_after_tick: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(alm_o) |-> $past(tick_i));
  a_r4_no_enable_no_hit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == '0) |-> !hit_i);
  a_r5_alarm_gate: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !alm_en_i |-> !hit_i);
  a_r5_int_off_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !int_en_i |-> irq_no);
  a_r6_latched_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!pulsed_i && int_en_i && alm_o) |-> !irq_no);
  a_r7_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_alm_i && !hit_i) |=> !alm_o);
  a_r8_pulse_width: assert property (@(posedge clk_i) disable iff (!rst_ni)
    low_run <= 16'(PULSE_W));
endmodule

bind rtc_alarm_irq rtc_alarm_irq_chk #(.PULSE_W(PULSE_W), .NF(rtc_alarm_pkg::NUM_FIELDS)) u_chk (
  .clk_i, .rst_ni, .tick_i, .clr_alm_i, .alm_o, .irq_no,
  .hit_i(hit), .en_i(fld_en), .alm_en_i(ctrl_q.alm_en),
  .int_en_i(ctrl_q.int_en), .pulsed_i(ctrl_q.pulsed)
);

// File: tb/tb_rtc_alarm_irq.sv
module tb_rtc_alarm_irq;
  localparam int NF = 6;
  localparam int FW = 7;
  localparam int PW = 4;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic           tick = 1'b0;
  logic [NF*FW-1:0] tm = '0;
  logic           wr_en = 1'b0;
  logic [2:0]     wr_addr = '0;
  logic [7:0]     wr_data = '0;
  logic           clr = 1'b0;
  logic           alm;
  logic           irq_n;

  always #4 clk = ~clk;

  rtc_alarm_irq #(.PULSE_W(PW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .time_i(tm),
    .wr_en_i(wr_en), .wr_addr_i(wr_addr), .wr_data_i(wr_data),
    .clr_alm_i(clr), .alm_o(alm), .irq_no(irq_n)
  );

  int n_tests = 0;
  int n_fail  = 0;

  // reference model
  logic [7:0] m_reg [NF];
  logic [7:0] m_ctrl = '0;
  logic       m_alm  = 1'b0;
  int         m_pc   = 0;

  function automatic logic m_hit();
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int k = 0; k < NF; k++) begin
      if (m_reg[k][7]) begin
        any = 1'b1;
        if (m_reg[k][6:0] != tm[k*FW +: FW]) ok = 1'b0;
      end
    end
    return tick && m_ctrl[7] && any && ok;
  endfunction

  function automatic logic m_irq_n();
    if (!m_ctrl[6]) return 1'b1;
    return m_ctrl[5] ? !(m_pc != 0) : !m_alm;
  endfunction

  function automatic logic [6:0] bcd(int v);
    return 7'(((v / 10) << 4) | (v % 10));
  endfunction

  function automatic logic [6:0] rnd_bcd(int lim);
    return bcd(int'($urandom % lim));
  endfunction

  task automatic check(string tag);
    n_tests++;
    if (alm !== m_alm || irq_n !== m_irq_n()) begin
      n_fail++;
      $display("FAIL %s: alm/irq_n actual %b/%b expected %b/%b",
               tag, alm, irq_n, m_alm, m_irq_n());
    end
  endtask

  task automatic cycle(string tag);
    logic h;
    @(posedge clk);
    h = m_hit();
    if (h) m_alm = 1'b1;
    else if (clr) m_alm = 1'b0;
    if (h && m_ctrl[5]) m_pc = PW;
    else if (m_pc > 0) m_pc--;
    if (wr_en) begin
      if (wr_addr < 3'(NF)) m_reg[wr_addr] = wr_data;
      else if (wr_addr == 3'd6) m_ctrl = wr_data;
    end
    @(negedge clk);
    check(tag);
    tick = 1'b0; wr_en = 1'b0; clr = 1'b0;
  endtask

  task automatic wr(int a, logic [7:0] d, string tag);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    cycle(tag);
  endtask

  task automatic do_tick(logic [NF*FW-1:0] t, string tag);
    tm = t; tick = 1'b1;
    cycle(tag);
  endtask

  task automatic do_clr(string tag);
    clr = 1'b1;
    cycle(tag);
  endtask

  function automatic logic [NF*FW-1:0] mk_time(int s, int mi, int h, int d, int mo, int w);
    return {bcd(w), bcd(mo), bcd(d), bcd(h), bcd(mi), bcd(s)};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog R2: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int edges;
    logic prev;
    void'($urandom(32'd20240611));
    for (int k = 0; k < NF; k++) m_reg[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    n_tests++;
    if (alm !== 1'b0 || irq_n !== 1'b1) begin
      n_fail++;
      $display("FAIL R1 reset: actual %b/%b expected 0/1", alm, irq_n);
    end
    rst_n = 1'b1;
    @(negedge clk);

    // R4: no enables, alarm on
    wr(6, 8'hC0, "R1");
    do_tick(mk_time(0, 0, 0, 0, 0, 0), "R4");
    do_tick(mk_time(30, 10, 5, 1, 1, 3), "R4");

    // latched 11:30:00 on 1 Jan
    wr(0, 8'h80, "R1"); wr(1, 8'hB0, "R1"); wr(2, 8'h91, "R1");
    wr(3, 8'h81, "R1"); wr(4, 8'h81, "R1"); wr(5, 8'h00, "R1");
    wr(7, 8'hFF, "R1");                       // ignored address
    do_tick(mk_time(59, 29, 11, 1, 1, 4), "R2");
    tm = mk_time(0, 30, 11, 1, 1, 4);
    cycle("R2");                              // no tick: no match
    do_tick(mk_time(0, 30, 11, 1, 1, 4), "R2");
    do_tick(mk_time(0, 30, 11, 1, 1, 6), "R3"); // weekday disabled
    cycle("R6");
    do_clr("R7");
    cycle("R7");
    tm = mk_time(0, 30, 11, 1, 1, 2); tick = 1'b1; clr = 1'b1;
    cycle("R7");                              // match beats clear
    do_clr("R7");

    // R5: interrupt disabled, then alarm disabled
    wr(6, 8'h80, "R5");
    do_tick(mk_time(0, 30, 11, 1, 1, 0), "R5");
    do_clr("R5");
    wr(6, 8'h40, "R5");
    do_tick(mk_time(0, 30, 11, 1, 1, 0), "R5");

    // R8: seconds-only 30, pulsed, two minutes
    for (int k = 0; k < NF; k++) wr(k, 8'h00, "R8");
    wr(0, 8'hB0, "R8");
    wr(6, 8'hE0, "R8");
    edges = 0;
    prev  = irq_n;
    for (int m = 0; m < 2; m++) begin
      for (int s = 0; s < 60; s++) begin
        do_tick(mk_time(s, m, 7, 15, 6, 2), "R8");
        if (prev && !irq_n) edges++;
        prev = irq_n;
        for (int i = 0; i < 5; i++) begin
          cycle("R8");
          if (prev && !irq_n) edges++;
          prev = irq_n;
        end
      end
    end
    n_tests++;
    if (edges != 2) begin
      n_fail++;
      $display("FAIL R8 pulse count: actual %0d expected 2", edges);
    end
    // retrigger inside a pulse
    do_tick(mk_time(30, 0, 0, 0, 0, 0), "R8");
    cycle("R8");
    do_tick(mk_time(30, 0, 0, 0, 0, 0), "R8");
    repeat (PW + 2) cycle("R8");

    // constrained random mix
    for (int it = 0; it < 600; it++) begin
      int op = int'($urandom % 10);
      if (op < 2) begin
        int a = int'($urandom % 8);
        logic [7:0] d = 8'($urandom);
        if (a == 6) d[7] = ($urandom % 4) != 0;
        wr(a, d, "R1");
      end else if (op < 7) begin
        logic [NF*FW-1:0] t;
        t = {rnd_bcd(7), rnd_bcd(13), rnd_bcd(32), rnd_bcd(24), rnd_bcd(60), rnd_bcd(60)};
        if ($urandom % 3 != 0)
          for (int k = 0; k < NF; k++)
            if (m_reg[k][7] || ($urandom % 2 == 0)) t[k*FW +: FW] = m_reg[k][6:0];
        do_tick(t, "R3");
      end else if (op < 8) begin
        do_clr("R7");
      end else begin
        cycle("R6");
      end
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule